// File: doc/BRIEF.md
# Table-Driven Header Field Extractor

This block sits beside a header identifier in a packet parser. It takes the packet as a stream of bytes, one byte per accepted cycle, and a second stream of identification records. Each record gives a header type, the byte offset where that header starts in the packet, and a flag that marks the packet's last header. Bytes are kept in a small circular buffer until the header they belong to has been handled. For each record, a fixed per-type table lists the byte positions, counted from the header start, that are to be copied. The block copies those bytes into slots of a wide register array, one byte per cycle.

Each header type owns a fixed range of slots and has one presence bit. When the last header's bytes have all been copied, the whole array and the presence bits are shown on the output for exactly one cycle together with a valid pulse. Any trailing bytes up to the end of the packet are then dropped. The array and the presence bits are cleared before the next packet begins. If bytes arrive much faster than records, the block does not drop data: it lowers its byte-ready output once the buffer is full.

The controller has four states. WAIT accepts a record and moves to COPY. COPY copies one listed byte per cycle, but only once that byte has arrived. When the entry's last byte is copied, COPY goes back to WAIT, or goes to EMIT if the record was marked final. EMIT raises the valid pulse and moves to DRAIN. DRAIN drops bytes until the end-of-packet byte has been accepted. It then clears the buffer counters, the slots and the presence bits, and returns to WAIT.

Top module: `fx_extract`

## Requirements
- R1: After reset, out_valid is 0, out_present is 0, and both in_ready and rec_ready are 1.
- R2: The extract table and the slot layout are as follows. Ethernet (type 0) takes bytes 0-5, 12 and 13 into slots 0-7. VLAN tag (type 1) takes bytes 0-3 into slots 8-11. IPv4 (type 2) takes bytes 1, 6, 8, 9 and 12-19 into slots 12-23. Transport ports (type 3) take bytes 0-3 into slots 24-27. Slot s occupies out_fields[8s+7:8s], and bytes are placed in the order listed.
- R3: A record is accepted only while rec_ready is 1, and records are handled in arrival order. A record may arrive before its header's bytes. Copying then waits for each byte, and the result is the same as when the bytes arrive first.
- R4: No more than BUF_DEPTH bytes are held beyond the end of the last completed header. At that point in_ready is 0, and no byte is lost.
- R5: out_valid is a one-cycle pulse, raised once per packet, and only after the final record has been accepted and all of its listed bytes have been copied.
- R6: out_present bit t is 1 exactly when a header of type t occurred in the packet.
- R7: Slots and presence bits are cleared between packets. Slots of header types absent from the packet read 0.
- R8: If a header type occurs more than once, its slots hold the bytes of the last occurrence.
- R9: After the byte marked in_last is accepted, in_ready stays 0 until the packet is finished. Bytes after the final header are dropped and do not affect the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Packet byte offered |
| in_ready | output | 1 | Packet byte accepted this cycle if valid |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Byte is the last byte of the packet |
| rec_valid | input | 1 | Identification record offered |
| rec_ready | output | 1 | Record accepted this cycle if valid |
| rec_type | input | 2 | Header type code (0 Ethernet, 1 VLAN, 2 IPv4, 3 ports) |
| rec_off | input | OFFW | Header start offset in the packet |
| rec_final | input | 1 | Record is the packet's last header |
| out_valid | output | 1 | Field vector valid pulse |
| out_present | output | 4 | Per-type presence bits |
| out_fields | output | 224 | Slot array, 28 bytes |

## Verification
The extractor is driven with several header stacks: Ethernet/IPv4/ports, Ethernet/VLAN/IPv4, Ethernet alone with a long payload, and a stack with two VLAN tags. The stacks show whether each table entry and its slot range are right, and whether a repeated type overwrites the earlier copy. The relative timing of the two streams is also varied. In one run, records arrive well ahead of the bytes, which tests the wait for bytes not yet received. In another, records are held back long enough to fill the buffer, which tests the stall and shows that no byte is dropped. Running packets back to back, with different stacks, shows that absent slots and presence bits from the previous packet do not carry over.

// File: rtl/fx_pkg.sv
package fx_pkg;
    localparam int NTYPES      = 4;
    localparam int TYPEW       = 2;
    localparam int KW          = 4;
    localparam int FIELD_BYTES = 28;
    localparam int FIELD_W     = FIELD_BYTES * 8;

    typedef enum logic [1:0] {
        HT_ETH  = 2'd0,
        HT_VLAN = 2'd1,
        HT_IP4  = 2'd2,
        HT_L4   = 2'd3
    } hdr_e;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_COPY,
        ST_EMIT,
        ST_DRAIN
    } st_e;

    // number of bytes listed for a header type
    function automatic logic [4:0] fx_cnt(input logic [1:0] t);
        case (t)
            HT_ETH:  return 5'd8;
            HT_VLAN: return 5'd4;
            HT_IP4:  return 5'd12;
            default: return 5'd4;
        endcase
    endfunction

    // byte position of entry k, relative to the header start
    function automatic logic [4:0] fx_pos(input logic [1:0] t, input logic [KW-1:0] k);
        logic [4:0] kk;
        kk = {1'b0, k};
        case (t)
            HT_ETH:  return (kk < 5'd6) ? kk : kk + 5'd6;
            HT_IP4: begin
                case (kk)
                    5'd0:    return 5'd1;
                    5'd1:    return 5'd6;
                    5'd2:    return 5'd8;
                    5'd3:    return 5'd9;
                    default: return kk + 5'd8;
                endcase
            end
            default: return kk;
        endcase
    endfunction

    // first slot owned by a header type
    function automatic logic [4:0] fx_base(input logic [1:0] t);
        case (t)
            HT_ETH:  return 5'd0;
            HT_VLAN: return 5'd8;
            HT_IP4:  return 5'd12;
            default: return 5'd24;
        endcase
    endfunction

    // bytes after which the header's data may be released
    function automatic logic [4:0] fx_span(input logic [1:0] t);
        case (t)
            HT_ETH:  return 5'd14;
            HT_VLAN: return 5'd4;
            HT_IP4:  return 5'd20;
            default: return 5'd4;
        endcase
    endfunction
endpackage

// File: rtl/fx_byte_buf.sv
module fx_byte_buf #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fx_field_store.sv
module fx_field_store
    import fx_pkg::*;
#(
    parameter int NSLOT = FIELD_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [4:0]         wr_slot,
    input  logic [7:0]         wr_data,
    input  logic               set_en,
    input  logic [TYPEW-1:0]   set_type,
    output logic [NSLOT*8-1:0] fields,
    output logic [NTYPES-1:0]  present
);
    // one register with its own input mux per slot
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                fields[8*g +: 8] <= '0;
            else if (clr)                              fields[8*g +: 8] <= '0;
            else if (wr_en && (wr_slot == 5'(g)))      fields[8*g +: 8] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      present <= '0;
        else if (clr)    present <= '0;
        else if (set_en) present[set_type] <= 1'b1;
    end
endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
    import fx_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int OFFW  = 8,
    parameter int CNTW  = OFFW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             rec_valid,
    input  logic [TYPEW-1:0] rec_type,
    input  logic [OFFW-1:0]  rec_off,
    input  logic             rec_final,
    output logic             rec_ready,
    output logic             wr_en,
    output logic [CNTW-1:0]  wr_addr,
    output logic [CNTW-1:0]  rd_addr,
    output logic             copy_en,
    output logic [4:0]       slot,
    output logic             set_en,
    output logic [TYPEW-1:0] set_type,
    output logic             clr,
    output logic             out_valid
);
    st_e              state_q, state_d;
    logic [TYPEW-1:0] type_q;
    logic [CNTW-1:0]  off_q, base_q, wcnt_q, target;
    logic             final_q, eop_q, byte_here, last_k, room, byte_acc;
    logic [KW-1:0]    k_q;

    assign target    = off_q + CNTW'(fx_pos(type_q, k_q));
    assign byte_here = target < wcnt_q;
    assign last_k    = ({1'b0, k_q} + 5'd1) == fx_cnt(type_q);
    assign room      = (wcnt_q - base_q) < CNTW'(DEPTH);

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = !eop_q && (room || state_q == ST_DRAIN);
        byte_acc  = in_valid && in_ready;
        rec_ready = state_q == ST_WAIT;
        copy_en   = state_q == ST_COPY && byte_here;
        set_en    = copy_en && last_k;
        clr       = state_q == ST_DRAIN && eop_q;
        out_valid = state_q == ST_EMIT;
        unique case (state_q)
            ST_WAIT:  if (rec_valid) state_d = ST_COPY;
            ST_COPY:  if (set_en)    state_d = final_q ? ST_EMIT : ST_WAIT;
            ST_EMIT:  state_d = ST_DRAIN;
            ST_DRAIN: if (eop_q)     state_d = ST_WAIT;
        endcase
    end

    assign wr_en    = byte_acc && state_q != ST_DRAIN;
    assign wr_addr  = wcnt_q;
    assign rd_addr  = target;
    assign slot     = fx_base(type_q) + {1'b0, k_q};
    assign set_type = type_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            type_q  <= '0;
            off_q   <= '0;
            final_q <= 1'b0;
            k_q     <= '0;
            base_q  <= '0;
            wcnt_q  <= '0;
            eop_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_en) wcnt_q <= wcnt_q + CNTW'(1);
            if (byte_acc && in_last) eop_q <= 1'b1;
            if (state_q == ST_WAIT && rec_valid) begin
                type_q  <= rec_type;
                off_q   <= CNTW'(rec_off);
                final_q <= rec_final;
                k_q     <= '0;
            end
            if (copy_en) begin
                k_q <= k_q + KW'(1);
                if (last_k) base_q <= off_q + CNTW'(fx_span(type_q));
            end
            if (clr) begin
                wcnt_q <= '0;
                base_q <= '0;
                eop_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fx_extract.sv
module fx_extract
    import fx_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    parameter int OFFW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [7:0]         in_data,
    input  logic               in_last,
    input  logic               rec_valid,
    output logic               rec_ready,
    input  logic [TYPEW-1:0]   rec_type,
    input  logic [OFFW-1:0]    rec_off,
    input  logic               rec_final,
    output logic               out_valid,
    output logic [NTYPES-1:0]  out_present,
    output logic [FIELD_W-1:0] out_fields
);
    localparam int AW   = $clog2(BUF_DEPTH);
    localparam int CNTW = OFFW + 1;

    logic             wr_en, copy_en, set_en, clr;
    logic [CNTW-1:0]  wr_addr, rd_addr;
    logic [4:0]       slot;
    logic [TYPEW-1:0] set_type;
    logic [7:0]       rd_data;

    fx_ctrl #(.DEPTH(BUF_DEPTH), .OFFW(OFFW), .CNTW(CNTW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .rec_valid(rec_valid), .rec_type(rec_type), .rec_off(rec_off),
        .rec_final(rec_final), .rec_ready(rec_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .copy_en(copy_en), .slot(slot), .set_en(set_en), .set_type(set_type),
        .clr(clr), .out_valid(out_valid)
    );

    fx_byte_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr[AW-1:0]), .wr_data(in_data),
        .rd_addr(rd_addr[AW-1:0]), .rd_data(rd_data)
    );

    fx_field_store #(.NSLOT(FIELD_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr_en(copy_en), .wr_slot(slot), .wr_data(rd_data),
        .set_en(set_en), .set_type(set_type),
        .fields(out_fields), .present(out_present)
    );
endmodule

// File: rtl/fx_extract_chk.sv
module fx_extract_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_last,
    input logic       rec_valid,
    input logic       rec_ready,
    input logic       rec_final,
    input logic       out_valid,
    input logic [3:0] out_present
);
    logic final_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    final_seen <= 1'b0;
        else if (out_valid)                            final_seen <= 1'b0;
        else if (rec_valid && rec_ready && rec_final)  final_seen <= 1'b1;
    end

    // R5
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5
    after_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> final_seen);

    // R9
    eop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R3
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready && rec_final) |=> !rec_ready);

    // R6
    present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_present != 4'd0);
endmodule

bind fx_extract fx_extract_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_final(rec_final), .out_valid(out_valid), .out_present(out_present)
);

// File: tb/fx_extract_tb_top.sv
module fx_extract_tb_top;
    localparam int FW = 224;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_last = 1'b0, rec_valid = 1'b0, rec_final = 1'b0;
    logic [7:0]    in_data = '0, rec_off = '0;
    logic [1:0]    rec_type = '0;
    logic          in_ready, rec_ready, out_valid;
    logic [3:0]    out_present;
    logic [FW-1:0] out_fields;

    int n_chk = 0, n_fail = 0, cyc = 0, acc_cnt = 0, pulses = 0;
    logic [7:0]    pkt [0:127];
    int            r_type [0:3];
    int            r_off  [0:3];
    int            nrec;
    logic [FW-1:0] cap_f;
    logic [3:0]    cap_p;

    always #10 clk = ~clk;

    fx_extract dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_type(rec_type), .rec_off(rec_off),
        .rec_final(rec_final), .out_valid(out_valid), .out_present(out_present),
        .out_fields(out_fields)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            pulses++;
            cap_f = out_fields;
            cap_p = out_present;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int t_cnt(input int t);
        case (t) 0: return 8; 1: return 4; 2: return 12; default: return 4; endcase
    endfunction
    function automatic int t_base(input int t);
        case (t) 0: return 0; 1: return 8; 2: return 12; default: return 24; endcase
    endfunction
    function automatic int t_pos(input int t, input int k);
        if (t == 0) return (k < 6) ? k : k + 6;
        if (t == 2) begin
            case (k) 0: return 1; 1: return 6; 2: return 8; 3: return 9; default: return k + 8; endcase
        end
        return k;
    endfunction

    task automatic fill_pkt(input int seed);
        for (int i = 0; i < 128; i++) pkt[i] = 8'((i * 37 + seed * 11 + 5) & 255);
    endtask

    task automatic drive_bytes(input int len, input int dly, input string req);
        repeat (dly) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pkt[i]; in_last = (i == len - 1);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            @(posedge clk);
            acc_cnt++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        #1;
        // R9: no byte taken after end of packet until finished
        chk(in_ready == 1'b0, {req, " R9 in_ready after in_last"}, FW'(in_ready), FW'(0));
    endtask

    task automatic drive_recs(input int dly);
        repeat (dly) @(negedge clk);
        for (int i = 0; i < nrec; i++) begin
            @(negedge clk);
            rec_valid = 1'b1; rec_type = 2'(r_type[i]); rec_off = 8'(r_off[i]);
            rec_final = (i == nrec - 1);
            #1;
            while (!rec_ready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk);
        rec_valid = 1'b0; rec_final = 1'b0;
    endtask

    task automatic run_pkt(input int len, input int bdly, input int rdly, input int stall_at, input string req);
        logic [FW-1:0] ef;
        logic [3:0]    ep;
        ef = '0; ep = '0;
        for (int r = 0; r < nrec; r++) begin
            for (int k = 0; k < t_cnt(r_type[r]); k++)
                ef[8 * (t_base(r_type[r]) + k) +: 8] = pkt[r_off[r] + t_pos(r_type[r], k)];
            ep[r_type[r]] = 1'b1;
        end
        pulses = 0; acc_cnt = 0;
        fork
            drive_bytes(len, bdly, req);
            drive_recs(rdly);
            begin
                if (stall_at > 0) begin
                    repeat (stall_at) @(negedge clk);
                    #2;
                    // R4: buffer full, byte input held, nothing dropped
                    chk(acc_cnt == 32 && in_ready == 1'b0, {req, " R4 stall at full buffer"},
                        FW'(acc_cnt), FW'(32));
                end
            end
        join
        for (int w = 0; w < 2000 && pulses == 0; w++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(pulses == 1, {req, " R5 one valid pulse"}, FW'(pulses), FW'(1));
        chk(cap_f == ef, {req, " fields"}, cap_f, ef);
        chk(cap_p == ep, {req, " R6 presence"}, FW'(cap_p), FW'(ep));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(out_valid == 0 && out_present == 0, "R1 outputs idle", FW'({out_valid, out_present}), FW'(0));
        chk(in_ready == 1 && rec_ready == 1, "R1 ready", FW'({in_ready, rec_ready}), FW'(3));
    endtask

    task automatic t_full_stack;   // R2, R6
        fill_pkt(1);
        nrec = 3;
        r_type[0] = 0; r_off[0] = 0; r_type[1] = 2; r_off[1] = 14; r_type[2] = 3; r_off[2] = 34;
        run_pkt(60, 0, 0, 0, "R2 eth/ip4/ports");
    endtask

    task automatic t_records_early;  // R3
        fill_pkt(2);
        nrec = 3;
        r_type[0] = 0; r_off[0] = 0; r_type[1] = 1; r_off[1] = 14; r_type[2] = 2; r_off[2] = 18;
        run_pkt(50, 25, 0, 0, "R3 records before bytes");
    endtask

    task automatic t_stall;  // R4, R7 (vlan slots from last packet must be zero)
        fill_pkt(3);
        nrec = 3;
        r_type[0] = 0; r_off[0] = 0; r_type[1] = 2; r_off[1] = 14; r_type[2] = 3; r_off[2] = 34;
        run_pkt(70, 0, 90, 75, "R4/R7 stall then resume");
    endtask

    task automatic t_eth_only;  // R9, R7
        fill_pkt(4);
        nrec = 1;
        r_type[0] = 0; r_off[0] = 0;
        run_pkt(45, 0, 3, 0, "R9/R7 single header long payload");
    endtask

    task automatic t_dup_vlan;  // R8
        fill_pkt(5);
        nrec = 4;
        r_type[0] = 0; r_off[0] = 0; r_type[1] = 1; r_off[1] = 14;
        r_type[2] = 1; r_off[2] = 18; r_type[3] = 2; r_off[3] = 22;
        run_pkt(48, 2, 0, 0, "R8 repeated vlan");
    endtask

    initial begin
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_stack();
        t_records_early();
        t_stall();
        t_eth_only();
        t_full_stack();
        t_dup_vlan();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule